// File: doc/BRIEF.md
# Priority Interrupt Resolver

This block collects interrupt requests from eleven sources and decides which one, if any, is offered to the processor. The sources are a non-maskable request, a break-condition request, a serial-debug request and eight external request lines. The non-maskable request has the fixed level 16. The break and serial-debug requests have the fixed level 15. Each external line carries its own 4-bit priority, and a priority of 0 masks that line for good.

The current 4-bit processor mask is an input. A maskable winner is offered only when its level is strictly above the mask. The non-maskable request is offered at any mask. With the request the block outputs the source identifier, the winning level, and the mask value the processor loads when it accepts. That value is the winning level, capped at 15.

The processor answers with a one-cycle acknowledge. The non-maskable and serial-debug requests are held in the block until they are acknowledged. The break request and the external lines follow their inputs, which arrive already conditioned by upstream sense logic.

Top module: `irq_resolver`

## Requirements
- R1: After reset `irq_o` is 0 and `src_id_o`, `irq_lvl_o` and `new_mask_o` are all 0.
- R2: An active external line k whose priority p is above the mask is offered with `src_id_o` = 8+k, `irq_lvl_o` = p and `new_mask_o` = p.
- R3: An external line whose priority is 0 is never offered, even with a mask of 0.
- R4: A maskable request whose level equals or is below `cur_mask_i` is not offered.
- R5: A one-cycle pulse on `nmi_i` sets a pending request. While that request is pending it is offered at any mask with `src_id_o` = 1, `irq_lvl_o` = 16 and `new_mask_o` = 15.
- R6: While `brk_i` is high, the break request is offered with `src_id_o` = 2, `irq_lvl_o` = 15 and `new_mask_o` = 15, but only when the mask is below 15. It disappears once `brk_i` falls.
- R7: A rising edge on `dbg_ser_i` sets a pending request with `src_id_o` = 3, level 15 and new mask 15. The request stays pending after the input falls and is cleared only when it is acknowledged.
- R8: The highest level wins. Among equal levels the order is non-maskable, break, serial-debug, then external line 7 down to line 0.
- R9: `ack_i` clears only the pending flag of the source being offered, and only if that source is non-maskable or serial-debug. Other pending flags and all level-following sources are left as they are.
- R10: Whenever `irq_o` is 0, `src_id_o`, `irq_lvl_o` and `new_mask_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request pulse from upstream edge detection |
| brk_i | input | 1 | Break-condition request, level |
| dbg_ser_i | input | 1 | Serial-debug request; its rising edge is captured |
| ext_req_i | input | 8 | External request lines, level, already sense-conditioned |
| ext_prio_i | input | 32 | Priority of line k in bits 4k+3..4k |
| cur_mask_i | input | 4 | Current processor mask level |
| ack_i | input | 1 | One-cycle acknowledge of the offered request |
| irq_o | output | 1 | Interrupt request to the processor |
| src_id_o | output | 4 | Winner: 1 non-maskable, 2 break, 3 serial-debug, 8+k external line k, 0 none |
| irq_lvl_o | output | 5 | Winning level, 0 to 16 |
| new_mask_o | output | 4 | Mask value to load on acceptance |

## Verification
Every request input is registered once. A change on `nmi_i`, `brk_i`, `dbg_ser_i` or `ext_req_i` therefore shows at the outputs just after the next rising edge. `ack_i` takes effect at the edge that samples it. `cur_mask_i` and `ext_prio_i` feed the comparison without a register, so their effect is visible in the same cycle. The bench drives inputs on the falling edge. It lets one rising edge pass and reads the outputs on the following falling edge, which matches the one-register latency of the sampled inputs and also covers the same-cycle inputs.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int PRIO_W  = 4;
    localparam int LVL_W   = PRIO_W + 1;
    localparam int N_EXT   = 8;
    localparam int ID_W    = $clog2(2 * N_EXT);
    localparam int N_FIXED = 3;
    localparam int N_CAND  = N_FIXED + N_EXT;

    localparam logic [LVL_W-1:0] LVL_NMI = LVL_W'(1 << PRIO_W);
    localparam logic [LVL_W-1:0] LVL_DBG = LVL_W'((1 << PRIO_W) - 1);

    typedef enum logic [ID_W-1:0] {
        SRC_NONE = ID_W'(0),
        SRC_NMI  = ID_W'(1),
        SRC_BRK  = ID_W'(2),
        SRC_SER  = ID_W'(3)
    } src_fixed_e;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [ID_W-1:0]  id;
    } cand_t;

    function automatic logic [ID_W-1:0] ext_id(input int line);
        return ID_W'(N_EXT + line);
    endfunction

    function automatic logic [PRIO_W-1:0] accept_mask(input logic [LVL_W-1:0] lvl);
        return (lvl > LVL_DBG) ? LVL_DBG[PRIO_W-1:0] : lvl[PRIO_W-1:0];
    endfunction

endpackage

// File: rtl/irq_res_capture.sv
module irq_res_capture
    import irq_res_pkg::*;
#(
    parameter int NUM_EXT = N_EXT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_i,
    input  logic               brk_i,
    input  logic               dbg_ser_i,
    input  logic [NUM_EXT-1:0] ext_req_i,
    input  logic               nmi_clr,
    input  logic               ser_clr,
    output logic               nmi_pend,
    output logic               ser_pend,
    output logic               brk_q,
    output logic [NUM_EXT-1:0] ext_q
);

    logic ser_prev;
    logic ser_rise;

    assign ser_rise = dbg_ser_i & ~ser_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend <= 1'b0;
            ser_pend <= 1'b0;
            ser_prev <= 1'b0;
            brk_q    <= 1'b0;
            ext_q    <= '0;
        end else begin
            nmi_pend <= (nmi_pend & ~nmi_clr) | nmi_i;
            ser_pend <= (ser_pend & ~ser_clr) | ser_rise;
            ser_prev <= dbg_ser_i;
            brk_q    <= brk_i;
            ext_q    <= ext_req_i;
        end
    end

    // R5
    nmi_capture_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_i |=> nmi_pend);

    // R7
    ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_pend && !ser_clr) |=> ser_pend);

    // R7
    ser_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_ser_i && !ser_prev) |=> ser_pend);

endmodule

// File: rtl/irq_res_arbiter.sv
module irq_res_arbiter
    import irq_res_pkg::*;
#(
    parameter int NUM_EXT = N_EXT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      nmi_pend,
    input  logic                      brk_q,
    input  logic                      ser_pend,
    input  logic [NUM_EXT-1:0]        ext_q,
    input  logic [NUM_EXT*PRIO_W-1:0] ext_prio,
    input  logic [PRIO_W-1:0]         cur_mask,
    output logic                      irq,
    output logic [ID_W-1:0]           src_id,
    output logic [LVL_W-1:0]          lvl,
    output logic [PRIO_W-1:0]         new_mask
);

    localparam int NCAND = N_FIXED + NUM_EXT;

    cand_t cand [NCAND];
    cand_t best;
    logic  present;

    assign cand[0] = '{vld: nmi_pend, lvl: LVL_NMI, id: SRC_NMI};
    assign cand[1] = '{vld: brk_q,    lvl: LVL_DBG, id: SRC_BRK};
    assign cand[2] = '{vld: ser_pend, lvl: LVL_DBG, id: SRC_SER};

    // External lines sit after the fixed sources, highest line first.
    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
        localparam int LINE = NUM_EXT - 1 - j;
        logic [PRIO_W-1:0] p;
        assign p = ext_prio[LINE*PRIO_W +: PRIO_W];
        assign cand[N_FIXED + j] = '{vld: ext_q[LINE] && (p != '0),
                                     lvl: {1'b0, p},
                                     id:  ext_id(LINE)};
    end

    // Walk from the lowest-ordered candidate upward; ">=" lets an earlier
    // entry in the tie order replace a later one of equal level.
    always_comb begin
        best = '0;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (cand[i].vld && (!best.vld || cand[i].lvl >= best.lvl)) begin
                best = cand[i];
            end
        end
    end

    assign present  = best.vld &&
                      ((best.id == SRC_NMI) || (best.lvl > {1'b0, cur_mask}));
    assign irq      = present;
    assign src_id   = present ? best.id : SRC_NONE;
    assign lvl      = present ? best.lvl : '0;
    assign new_mask = present ? accept_mask(best.lvl) : '0;

    // R4
    above_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && src_id != SRC_NMI) |-> (lvl > {1'b0, cur_mask}));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (src_id == '0 && lvl == '0 && new_mask == '0));

    // R5
    nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (irq && src_id == SRC_NMI && new_mask == LVL_DBG[PRIO_W-1:0]));

    // R3
    zero_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && src_id[ID_W-1]) |-> (lvl != '0));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int NUM_EXT = N_EXT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      nmi_i,
    input  logic                      brk_i,
    input  logic                      dbg_ser_i,
    input  logic [NUM_EXT-1:0]        ext_req_i,
    input  logic [NUM_EXT*PRIO_W-1:0] ext_prio_i,
    input  logic [PRIO_W-1:0]         cur_mask_i,
    input  logic                      ack_i,
    output logic                      irq_o,
    output logic [ID_W-1:0]           src_id_o,
    output logic [LVL_W-1:0]          irq_lvl_o,
    output logic [PRIO_W-1:0]         new_mask_o
);

    logic               nmi_pend, ser_pend, brk_q;
    logic [NUM_EXT-1:0] ext_q;
    logic               nmi_clr, ser_clr;

    assign nmi_clr = ack_i && irq_o && (src_id_o == SRC_NMI);
    assign ser_clr = ack_i && irq_o && (src_id_o == SRC_SER);

    irq_res_capture #(.NUM_EXT(NUM_EXT)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .nmi_i     (nmi_i),
        .brk_i     (brk_i),
        .dbg_ser_i (dbg_ser_i),
        .ext_req_i (ext_req_i),
        .nmi_clr   (nmi_clr),
        .ser_clr   (ser_clr),
        .nmi_pend  (nmi_pend),
        .ser_pend  (ser_pend),
        .brk_q     (brk_q),
        .ext_q     (ext_q)
    );

    irq_res_arbiter #(.NUM_EXT(NUM_EXT)) arb_i (
        .clk      (clk),
        .rst      (rst),
        .nmi_pend (nmi_pend),
        .brk_q    (brk_q),
        .ser_pend (ser_pend),
        .ext_q    (ext_q),
        .ext_prio (ext_prio_i),
        .cur_mask (cur_mask_i),
        .irq      (irq_o),
        .src_id   (src_id_o),
        .lvl      (irq_lvl_o),
        .new_mask (new_mask_o)
    );

    // R9
    ack_keeps_ser_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_pend && !ser_clr) |=> ser_pend);

    // R9
    ack_keeps_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !nmi_clr) |=> nmi_pend);

endmodule

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        nmi_i, brk_i, dbg_ser_i, ack_i;
    logic [7:0]  ext_req_i;
    logic [31:0] ext_prio_i;
    logic [3:0]  cur_mask_i;
    logic        irq_o;
    logic [3:0]  src_id_o;
    logic [4:0]  irq_lvl_o;
    logic [3:0]  new_mask_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_resolver dut_i (
        .clk(clk), .rst(rst), .nmi_i(nmi_i), .brk_i(brk_i),
        .dbg_ser_i(dbg_ser_i), .ext_req_i(ext_req_i), .ext_prio_i(ext_prio_i),
        .cur_mask_i(cur_mask_i), .ack_i(ack_i), .irq_o(irq_o),
        .src_id_o(src_id_o), .irq_lvl_o(irq_lvl_o), .new_mask_o(new_mask_o)
    );

    task automatic expect_out(input string req, input logic e_irq,
                              input int e_src, input int e_lvl, input int e_nm);
        n_checks++;
        if (irq_o !== e_irq || src_id_o !== 4'(e_src) ||
            irq_lvl_o !== 5'(e_lvl) || new_mask_o !== 4'(e_nm)) begin
            n_fail++;
            $display("FAIL %s: got irq=%0b src=%0d lvl=%0d nm=%0d, want irq=%0b src=%0d lvl=%0d nm=%0d",
                     req, irq_o, src_id_o, irq_lvl_o, new_mask_o,
                     e_irq, e_src, e_lvl, e_nm);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int line, input int p);
        ext_prio_i[line*4 +: 4] = 4'(p);
    endtask

    task automatic quiet;
        nmi_i = 0; brk_i = 0; dbg_ser_i = 0; ack_i = 0;
        ext_req_i = '0; ext_prio_i = '0; cur_mask_i = '0;
    endtask

    task automatic t_reset;
        quiet();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        // R1
        expect_out("R1", 0, 0, 0, 0);
    endtask

    task automatic t_ext_basic;
        quiet(); step();
        set_prio(3, 5); ext_req_i[3] = 1; cur_mask_i = 2;
        step();
        // R2
        expect_out("R2", 1, 11, 5, 5);
        cur_mask_i = 5;
        step();
        // R4 equal level
        expect_out("R4", 0, 0, 0, 0);
        cur_mask_i = 4;
        step();
        expect_out("R2", 1, 11, 5, 5);
        set_prio(3, 0); cur_mask_i = 0;
        step();
        // R3
        expect_out("R3", 0, 0, 0, 0);
        quiet(); step();
        // R10
        expect_out("R10", 0, 0, 0, 0);
    endtask

    task automatic t_ext_ties;
        quiet(); step();
        set_prio(2, 7); set_prio(6, 7); ext_req_i[2] = 1; ext_req_i[6] = 1;
        step();
        // R8 equal ext priority: higher line wins
        expect_out("R8", 1, 14, 7, 7);
        set_prio(1, 9); ext_req_i[1] = 1;
        step();
        // R8 higher level beats order
        expect_out("R8", 1, 9, 9, 9);
        ack_i = 1;
        step();
        ack_i = 0;
        // R9 ack leaves level sources in place
        expect_out("R9", 1, 9, 9, 9);
    endtask

    task automatic t_brk;
        quiet(); step();
        brk_i = 1; cur_mask_i = 14; set_prio(7, 15); ext_req_i[7] = 1;
        step();
        // R6 and R8: break beats line 7 at level 15
        expect_out("R6", 1, 2, 15, 15);
        cur_mask_i = 15;
        step();
        expect_out("R6", 0, 0, 0, 0);
        cur_mask_i = 0; brk_i = 0;
        step();
        expect_out("R6", 1, 15, 15, 15);
    endtask

    task automatic t_ser;
        quiet(); step();
        dbg_ser_i = 1;
        step();
        dbg_ser_i = 0;
        // R7
        expect_out("R7", 1, 3, 15, 15);
        step(); step(); step();
        expect_out("R7", 1, 3, 15, 15);
        cur_mask_i = 15;
        step();
        ack_i = 1;
        step();
        ack_i = 0;
        cur_mask_i = 0;
        step();
        // R9 ack while not offered leaves it pending
        expect_out("R9", 1, 3, 15, 15);
        ack_i = 1;
        step();
        ack_i = 0;
        // R7 cleared by acknowledge
        expect_out("R7", 0, 0, 0, 0);
    endtask

    task automatic t_nmi;
        quiet(); step();
        cur_mask_i = 15; nmi_i = 1;
        step();
        nmi_i = 0;
        // R5
        expect_out("R5", 1, 1, 16, 15);
        cur_mask_i = 0; brk_i = 1; dbg_ser_i = 1;
        step();
        // R8 non-maskable beats break and serial-debug
        expect_out("R8", 1, 1, 16, 15);
        dbg_ser_i = 0; ack_i = 1;
        step();
        ack_i = 0;
        // R9 break wins next
        expect_out("R9", 1, 2, 15, 15);
        brk_i = 0;
        step();
        // R9 serial-debug flag survived the ack
        expect_out("R9", 1, 3, 15, 15);
        ack_i = 1;
        step();
        ack_i = 0;
        expect_out("R10", 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        quiet();
        @(negedge clk);
        t_reset();
        t_ext_basic();
        t_ext_ties();
        t_brk();
        t_ser();
        t_nmi();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule